// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address by walking a two-level page table held in memory. A request carries the virtual address, an access kind (read, write or execute) and the base address of the top-level table. The walker reads one word from the top-level table and, if that word is marked present, one word from the second-level table it points to. It then checks the leaf word for presence and permission, sets the reference and modify flags where needed, and returns either a physical address with the final entry or a fault code.

Requests come in through a ready/valid handshake, one at a time. The response leaves through its own ready/valid handshake. Memory is reached through a simple request/response port. A request is held until the memory accepts it, and the memory returns one response pulse for each accepted request, whether it is a read or a write.

The virtual address splits into three fields. Bits 31:20 index the top-level table, bits 19:12 index the second-level table, and bits 11:0 are the page offset. Every table entry is a 32-bit word with this layout:
- bit 31: present
- bit 30: referenced
- bit 29: modified
- bits 28:27: protection
- bits 19:0: frame number

Top module: `pt_walker`

## Requirements
- R1: The first memory access of a walk is a read at `root_base + 4 * vaddr[31:20]`.
- R2: If the top-level entry has bit 31 set, the second access is a read at `{entry[19:0], 12'h000} + 4 * vaddr[19:12]`.
- R3: If the top-level entry has bit 31 clear, the walk ends after that single read. It reports fault code 01 (not present) and does no write.
- R4: If the leaf entry has bit 31 clear, the walk reports fault code 01 and does no write.
- R5: Access codes are 00 read, 01 write, 10 execute and 11 reserved. Leaf protection codes are 00 none, 01 read-only, 10 read/write and 11 execute-only. Read is allowed under 01 or 10, write only under 10, and execute only under 11. Code 11 is never allowed. A disallowed access reports fault code 10, with no write-back, even when the entry is present.
- R6: On success the fault code is 00, `rsp_paddr = {leaf[19:0], vaddr[11:0]}`, and `rsp_pte` is the leaf entry after any flag update. On a fault, `rsp_paddr` is zero.
- R7: On a permitted access the walker sets bit 30 of the leaf entry. On a write it also sets bit 29. When this changes the word, the new word is written back to the leaf address before the response is given.
- R8: When the referenced and modified bits already hold the values the access needs, no write-back is issued.
- R9: `req_ready` is high only while idle. A response stays valid and unchanged until `rsp_ready` is high. A memory request stays unchanged until `mem_req_ready` is high. Reset returns the walker to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| root_base | input | 32 | Byte address of the top-level table |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Word byte address |
| mem_req_wdata | output | 32 | Write data (updated leaf entry) |
| mem_rsp_valid | input | 1 | Memory response pulse |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_pte | output | 32 | Final entry reached |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
The bench builds the walker with its default 12/8/12 split. This puts the arithmetic at both ends of the table indices within reach: index zero, and the all-ones address whose table offsets reach 0x3FFC and 0x3FC. The vector table runs twice, first against a memory that accepts at once and then against one that stalls for several cycles per request, so the held-request rule is exercised on reads and on write-backs. Directed tests add consumer back-pressure on the response and a reset in the middle of a walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int MIDX_W = 12,
  parameter int SIDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic [31:0] root_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_pte,
  output logic [1:0]  rsp_fault
);
  localparam int OFF_W = 32 - MIDX_W - SIDX_W;
  localparam int PFN_W = 32 - OFF_W;
  localparam int BIT_V = 31;
  localparam int BIT_R = 30;
  localparam int BIT_M = 29;
  localparam int PROT_LO = 27;

  typedef enum logic [2:0] {IDLE, MREQ, MWAIT, SREQ, SWAIT, WREQ, WWAIT, RESP} st_t;

  st_t         st;
  logic [31:0] va, addr, pte;
  logic [1:0]  acc, fault;

  logic [1:0]  prot;
  logic        allow;
  logic [31:0] upd;

  assign prot = mem_rsp_rdata[PROT_LO +: 2];
  assign allow = (acc == 2'b00) ? (prot == 2'b01 || prot == 2'b10) :
                 (acc == 2'b01) ? (prot == 2'b10) :
                 (acc == 2'b10) ? (prot == 2'b11) : 1'b0;
  assign upd = mem_rsp_rdata | (32'b1 << BIT_R) | ((acc == 2'b01) ? (32'b1 << BIT_M) : 32'b0);

  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st == MREQ) || (st == SREQ) || (st == WREQ);
  assign mem_req_we    = (st == WREQ);
  assign mem_req_addr  = addr;
  assign mem_req_wdata = pte;
  assign rsp_valid     = (st == RESP);
  assign rsp_pte       = pte;
  assign rsp_fault     = fault;
  assign rsp_paddr     = (fault == 2'b00) ? {pte[PFN_W-1:0], va[OFF_W-1:0]} : 32'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      va    <= '0;
      addr  <= '0;
      pte   <= '0;
      acc   <= '0;
      fault <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va    <= req_vaddr;
          acc   <= req_acc;
          fault <= 2'b00;
          addr  <= root_base + 32'({req_vaddr[31 -: MIDX_W], 2'b00});
          st    <= MREQ;
        end
        MREQ: if (mem_req_ready) st <= MWAIT;
        MWAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_rdata[BIT_V]) begin
            pte   <= mem_rsp_rdata;
            fault <= 2'b01;
            st    <= RESP;
          end else begin
            addr <= {mem_rsp_rdata[PFN_W-1:0], {OFF_W{1'b0}}} + 32'({va[OFF_W +: SIDX_W], 2'b00});
            st   <= SREQ;
          end
        end
        SREQ: if (mem_req_ready) st <= SWAIT;
        SWAIT: if (mem_rsp_valid) begin
          pte <= mem_rsp_rdata;
          if (!mem_rsp_rdata[BIT_V]) begin
            fault <= 2'b01;
            st    <= RESP;
          end else if (!allow) begin
            fault <= 2'b10;
            st    <= RESP;
          end else if (upd != mem_rsp_rdata) begin
            pte <= upd;
            st  <= WREQ;
          end else begin
            st <= RESP;
          end
        end
        WREQ:  if (mem_req_ready) st <= WWAIT;
        WWAIT: if (mem_rsp_valid) st <= RESP;
        RESP:  if (rsp_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic [31:0] rsp_pte,
  input logic [1:0]  rsp_fault
);
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_pte));

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (rsp_valid || mem_req_valid)));

  assert_wb_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[31] && mem_req_wdata[30]);

  assert_ok_referenced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'b00 |-> rsp_pte[31] && rsp_pte[30]);

  assert_prot_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'b10 |-> rsp_pte[31]);

  assert_fault_paddr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'b00 |-> rsp_paddr == 32'b0);

  assert_fault_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_pte(rsp_pte), .rsp_fault(rsp_fault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_acc = 0;
  logic [31:0] root_base = 32'h0010_0000;
  logic        mem_req_valid, mem_req_ready = 0, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_rdata = 0;
  logic        rsp_valid, rsp_ready = 1;
  logic [31:0] rsp_paddr, rsp_pte;
  logic [1:0]  rsp_fault;

  pt_walker u_pt_walker (.*);

  int checks = 0, errors = 0;
  logic        stall = 0;
  logic [7:0]  cyc = 0;
  logic [31:0] ma = 0, md = 0, la = 0, ld = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_log [0:255];
  logic [31:0] wr_addr = 0, wr_data = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= !stall || (cyc[1:0] == 2'b11);
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_we) begin
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_req_addr;
        wr_data <= mem_req_wdata;
      end else begin
        rd_log[rd_cnt[7:0]] <= mem_req_addr;
        rd_cnt <= rd_cnt + 1;
        mem_rsp_rdata <= (mem_req_addr == ma) ? md : (mem_req_addr == la) ? ld : 32'h0;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [31:0] mpte;
    logic [31:0] lpte;
    logic [1:0]  f;
    logic [31:0] pa;
    logic        wb;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 2'b00, 32'h8000_0200, 32'h9000_1010, 2'b00, 32'h0101_0678, 1'b1, 32'hD000_1010},
    '{32'h1234_5678, 2'b01, 32'h8000_0200, 32'h9000_1010, 2'b00, 32'h0101_0678, 1'b1, 32'hF000_1010},
    '{32'h1234_5678, 2'b01, 32'h8000_0200, 32'h8800_1010, 2'b10, 32'h0,         1'b0, 32'h0},
    '{32'h1234_5678, 2'b10, 32'h8000_0200, 32'h9800_1010, 2'b00, 32'h0101_0678, 1'b1, 32'hD800_1010},
    '{32'h1234_5678, 2'b00, 32'h8000_0200, 32'h9800_1010, 2'b10, 32'h0,         1'b0, 32'h0},
    '{32'h1234_5678, 2'b00, 32'h8000_0200, 32'h8000_1010, 2'b10, 32'h0,         1'b0, 32'h0},
    '{32'h1234_5678, 2'b00, 32'h0000_0200, 32'h9000_1010, 2'b01, 32'h0,         1'b0, 32'h0},
    '{32'h1234_5678, 2'b00, 32'h8000_0200, 32'h1000_1010, 2'b01, 32'h0,         1'b0, 32'h0},
    '{32'h1234_5678, 2'b00, 32'h8000_0200, 32'hD000_1010, 2'b00, 32'h0101_0678, 1'b0, 32'h0},
    '{32'h1234_5678, 2'b01, 32'h8000_0200, 32'hF000_1010, 2'b00, 32'h0101_0678, 1'b0, 32'h0},
    '{32'h1234_5678, 2'b01, 32'h8000_0200, 32'hD000_1010, 2'b00, 32'h0101_0678, 1'b1, 32'hF000_1010},
    '{32'h1234_5678, 2'b11, 32'h8000_0200, 32'h9000_1010, 2'b10, 32'h0,         1'b0, 32'h0},
    '{32'hFFFF_FFFF, 2'b00, 32'h800A_BCDE, 32'h9000_F00D, 2'b00, 32'h0F00_DFFF, 1'b1, 32'hD000_F00D},
    '{32'h0000_0000, 2'b00, 32'h8000_0000, 32'h8800_0001, 2'b00, 32'h0000_1000, 1'b1, 32'hC800_0001}
  };

  task automatic run(input vec_t v, input int idx);
    int rd0, wr0;
    ma = root_base + {18'b0, v.va[31:20], 2'b00};
    md = v.mpte;
    la = {v.mpte[19:0], 12'h000} + {22'b0, v.va[19:12], 2'b00};
    ld = v.lpte;
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1; req_vaddr = v.va; req_acc = v.acc;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(32'(rsp_fault), 32'(v.f), $sformatf("R3/R4/R5 fault code, vector %0d", idx));
    chk(rsp_paddr, v.pa, $sformatf("R6 physical address, vector %0d", idx));
    chk(rd_log[rd0[7:0]], ma, $sformatf("R1 top-level read address, vector %0d", idx));
    if (!v.mpte[31]) begin
      chk(32'(rd_cnt - rd0), 32'd1, $sformatf("R3 single read, vector %0d", idx));
    end else begin
      chk(32'(rd_cnt - rd0), 32'd2, $sformatf("R2 two reads, vector %0d", idx));
      chk(rd_log[8'(rd0 + 1)], la, $sformatf("R2 leaf read address, vector %0d", idx));
    end
    chk(32'(wr_cnt - wr0), v.wb ? 32'd1 : 32'd0, $sformatf("R7/R8 write-back count, vector %0d", idx));
    if (v.wb) begin
      chk(wr_addr, la, $sformatf("R7 write-back address, vector %0d", idx));
      chk(wr_data, v.wd, $sformatf("R7 write-back data, vector %0d", idx));
    end
    if (v.f == 2'b00)
      chk(rsp_pte, v.wb ? v.wd : v.lpte, $sformatf("R6 returned entry, vector %0d", idx));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(32'(req_ready), 32'd1, "R9 reset req_ready");
    chk(32'(rsp_valid), 32'd0, "R9 reset rsp_valid");
    chk(32'(mem_req_valid), 32'd0, "R9 reset mem_req_valid");
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run(VECS[i], i);
    stall = 1;
    for (int i = 0; i < NV; i++) run(VECS[i], i);
    stall = 0;

    rsp_ready = 0;
    ma = root_base + 32'h48C; md = 32'h8000_0200;
    la = 32'h0020_0114;       ld = 32'h9000_1010;
    @(negedge clk);
    req_valid = 1; req_vaddr = 32'h1234_5678; req_acc = 2'b00;
    @(negedge clk);
    req_valid = 0;
    chk(32'(req_ready), 32'd0, "R9 busy req_ready");
    while (!rsp_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(32'(rsp_valid), 32'd1, "R9 response held");
    chk(rsp_paddr, 32'h0101_0678, "R9 held paddr");
    rsp_ready = 1;
    @(negedge clk);
    chk(32'(rsp_valid), 32'd0, "R9 response released");
    chk(32'(req_ready), 32'd1, "R9 idle after release");

    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(32'(req_ready), 32'd1, "R9 mid-walk reset req_ready");
    chk(32'(mem_req_valid), 32'd0, "R9 mid-walk reset mem_req_valid");
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(32'(rsp_valid), 32'd0, "R9 no response after reset");
    run(VECS[0], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule